// File: doc/BRIEF.md
# Ethernet Media Autoselect Sequencer

This block chooses which transceiver port a multi-media Ethernet controller drives. It resolves three modes in priority order: a forced port from an override input, a fixed default port when automatic selection is off, or a hunt along a fixed chain of candidate ports. During the hunt each candidate is tested against a vector of transceiver-present bits. The first port found present becomes active. The block then gives the link that port's own settle time. Only after that time does it look at link status, and a link that is down sends the hunt on to the next port in the chain.

For the chosen port the block drives the media-control bits that the port needs (link beat, jabber, SQE counting). It also gives single-cycle pulses to power the thin-coax transceiver up or down as that port is entered or left. Settle times are set in tenths of a second and scaled by a tick-rate parameter, so the same logic serves any clock. All pins are plain control and status levels or pulses. No data stream passes through the block, so there is no back-pressure.

Top module: `media_autoselect`

## Requirements
- R1: When `override_code` is not 7, `media_code` shows that value one clock later, except that an override of 2 shows 0.
- R2: When `override_code` is 7 and `autosel_en` is low, `media_code` shows `default_code` one clock later.
- R3: When `override_code` is 7 and `autosel_en` is high, the hunt starts at code 4 and follows the chain 4→5→6→0→3→1→8. It takes the first code whose presence bit is set. The presence bits are bit 1 for code 4, bit 2 for 5, bit 6 for 6, bit 3 for 0, bit 4 for 3 and bit 5 for 1. Code 8 accepts any set bit.
- R4: `media_ctrl` is 0x00C0 for code 0, 0x0008 for code 1, 0x0080 for codes 4 and 5, and 0 for every other code.
- R5: A chosen port is held for its settle time before the link is examined. The settle time is 14 tenths for codes 0, 4 and 5, 1 tenth for codes 1 and 3, 30 tenths for code 6 and 1000 tenths otherwise, each tenth being `TICKS_PER_TENTH` clocks. If `link_up` is low once the settle time has passed, the hunt moves to the next code in the chain.
- R6: `coax_start` pulses for one clock in the cycle where `media_code` becomes 3. `coax_stop` pulses for one clock in the cycle where it leaves 3.
- R7: If a whole pass of the chain finds nothing present, `media_code` takes `default_code` and `search_fail` goes high. `search_fail` stays high until the hunt restarts.
- R8: The hunt restarts from code 4 whenever `present_mask` changes or automatic mode is entered. While automatic mode is off, changes on `present_mask` leave `media_code` unchanged.
- R9: After reset `media_code` is 8, `media_ctrl` is 0, and `search_fail`, `coax_start` and `coax_stop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| present_mask | input | 8 | Transceiver-present bits |
| override_code | input | 3 | Forced port code; 7 means no override |
| default_code | input | 4 | Port used when not hunting or when the hunt fails |
| autosel_en | input | 1 | Enables the chain hunt |
| link_up | input | 1 | Link status of the active port |
| media_code | output | 4 | Selected port code |
| media_ctrl | output | 16 | Media-control bits for the selected port |
| coax_start | output | 1 | One-clock pulse on entering code 3 |
| coax_stop | output | 1 | One-clock pulse on leaving code 3 |
| search_fail | output | 1 | High when the hunt found no present port |

## Verification
The bench builds the block with `TICKS_PER_TENTH` set to 2. This makes the 1.4 s settle window 28 clocks, short enough to step a link-down fallback through several ports in a few dozen cycles. Because the present vector is only 8 bits wide, the bench can sweep every value and compare each result with a chain walk it computes itself. It also sweeps every override value and every default code.

// File: rtl/media_sel_pkg.sv
package media_sel_pkg;

  typedef logic [3:0] mcode_t;

  localparam mcode_t M_10T   = 4'd0;
  localparam mcode_t M_AUI   = 4'd1;
  localparam mcode_t M_COAX  = 4'd3;
  localparam mcode_t M_TX    = 4'd4;
  localparam mcode_t M_DEF   = 4'd8;

  // distinct candidates visited from the hunt start before it must give up
  localparam int CHAIN_LEN = 7;

  typedef enum logic [1:0] {
    ST_SEARCH,
    ST_SETTLE,
    ST_ACTIVE,
    ST_FAIL
  } sel_state_t;

  function automatic logic [7:0] presence_bit(input mcode_t c);
    case (c)
      4'd0:    return 8'h08;
      4'd1:    return 8'h20;
      4'd2:    return 8'h80;
      4'd3:    return 8'h10;
      4'd4:    return 8'h02;
      4'd5:    return 8'h04;
      4'd6:    return 8'h40;
      4'd7:    return 8'h01;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic mcode_t chain_next(input mcode_t c);
    case (c)
      4'd0:    return 4'd3;
      4'd1:    return 4'd8;
      4'd3:    return 4'd1;
      4'd4:    return 4'd5;
      4'd5:    return 4'd6;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [15:0] ctrl_bits(input mcode_t c);
    case (c)
      4'd0:       return 16'h00C0;
      4'd1:       return 16'h0008;
      4'd4, 4'd5: return 16'h0080;
      default:    return 16'h0000;
    endcase
  endfunction

  function automatic logic [9:0] settle_tenths(input mcode_t c);
    case (c)
      4'd0, 4'd4, 4'd5: return 10'd14;
      4'd1, 4'd3:       return 10'd1;
      4'd6:             return 10'd30;
      default:          return 10'd1000;
    endcase
  endfunction

endpackage

// File: rtl/media_attr.sv
module media_attr
  import media_sel_pkg::*;
(
  input  mcode_t     code,
  input  logic [7:0] present,
  output logic       hit,
  output mcode_t     next_code,
  output logic [9:0] tenths
);
  always_comb begin
    hit       = |(presence_bit(code) & present);
    next_code = chain_next(code);
    tenths    = settle_tenths(code);
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         abort,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] count;
  logic         running;

  assign done = running && (count == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (abort) begin
      running <= 1'b0;
    end else if (load) begin
      count   <= load_val;
      running <= 1'b1;
    end else if (running) begin
      if (count == '0) running <= 1'b0;
      else             count   <= count - 1'b1;
    end
  end

  // R5
  tick_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && count != '0 && !load && !abort) |=> (count == $past(count) - 1'b1));

  // R5
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> !done);
endmodule

// File: rtl/coax_edge.sv
module coax_edge
  import media_sel_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  mcode_t code,
  output logic   start_p,
  output logic   stop_p
);
  mcode_t prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= M_DEF;
    else        prev <= code;
  end

  assign start_p = (code == M_COAX) && (prev != M_COAX);
  assign stop_p  = (code != M_COAX) && (prev == M_COAX);

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !start_p);

  // R6
  stop_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !stop_p);
endmodule

// File: rtl/media_autoselect.sv
module media_autoselect
  import media_sel_pkg::*;
#(
  parameter int unsigned TICKS_PER_TENTH = 12_500_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  present_mask,
  input  logic [2:0]  override_code,
  input  logic [3:0]  default_code,
  input  logic        autosel_en,
  input  logic        link_up,
  output logic [3:0]  media_code,
  output logic [15:0] media_ctrl,
  output logic        coax_start,
  output logic        coax_stop,
  output logic        search_fail
);
  localparam longint unsigned MAX_TICKS = 64'(1000) * 64'(TICKS_PER_TENTH);
  localparam int TW = $clog2(MAX_TICKS + 1);
  localparam logic [2:0] LAST_MISS = 3'(CHAIN_LEN - 1);

  sel_state_t state;
  mcode_t     cand, cand_next, code_q, code_nxt, forced;
  logic [2:0] misses;
  logic [7:0] present_q;
  logic       auto_mode, restart, cand_hit, tmr_load, tmr_done;
  logic [9:0] cand_tenths;
  logic [TW-1:0] tmr_val;

  media_attr u_attr (
    .code      (cand),
    .present   (present_mask),
    .hit       (cand_hit),
    .next_code (cand_next),
    .tenths    (cand_tenths)
  );

  assign auto_mode = (override_code == 3'd7) && autosel_en;
  assign restart   = !auto_mode || (present_mask != present_q);
  assign forced    = (override_code == 3'd2) ? M_10T : {1'b0, override_code};
  assign tmr_load  = !restart && (state == ST_SEARCH) && cand_hit;
  assign tmr_val   = TW'(cand_tenths) * TW'(TICKS_PER_TENTH) - TW'(1);

  settle_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .abort    (restart),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_SEARCH;
      cand      <= M_TX;
      misses    <= '0;
      present_q <= '0;
    end else begin
      present_q <= present_mask;
      if (restart) begin
        state  <= ST_SEARCH;
        cand   <= M_TX;
        misses <= '0;
      end else begin
        case (state)
          ST_SEARCH: begin
            if (cand_hit) begin
              state <= ST_SETTLE;
            end else if (misses == LAST_MISS) begin
              state <= ST_FAIL;
            end else begin
              cand   <= cand_next;
              misses <= misses + 1'b1;
            end
          end
          ST_SETTLE: if (tmr_done) state <= ST_ACTIVE;
          ST_ACTIVE: begin
            if (!link_up) begin
              state  <= ST_SEARCH;
              cand   <= cand_next;
              misses <= '0;
            end
          end
          default: state <= ST_FAIL;
        endcase
      end
    end
  end

  always_comb begin
    if (override_code != 3'd7)  code_nxt = forced;
    else if (!autosel_en)       code_nxt = default_code;
    else begin
      case (state)
        ST_SETTLE, ST_ACTIVE: code_nxt = cand;
        ST_FAIL:              code_nxt = default_code;
        default:              code_nxt = code_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= M_DEF;
    else        code_q <= code_nxt;
  end

  coax_edge u_coax (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (code_q),
    .start_p (coax_start),
    .stop_p  (coax_stop)
  );

  assign media_code  = code_q;
  assign media_ctrl  = ctrl_bits(code_q);
  assign search_fail = (state == ST_FAIL);

  // R1
  forced_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (override_code != 3'd7) |=>
      (media_code == (($past(override_code) == 3'd2) ? 4'd0 : {1'b0, $past(override_code)})));

  // R3
  settle_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETTLE && !restart) |-> cand_hit);

  // R5
  link_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && !link_up && !restart) |=> (state == ST_SEARCH));

  // R7
  fail_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (search_fail && $past(search_fail) && auto_mode) |-> (media_code == $past(default_code)));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (present_mask != present_q) |=> (state == ST_SEARCH && cand == M_TX));
endmodule

// File: tb/media_autoselect_test.sv
module media_autoselect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  present_mask = 8'h00;
  logic [2:0]  override_code = 3'd7;
  logic [3:0]  default_code = 4'd0;
  logic        autosel_en = 1'b0;
  logic        link_up = 1'b1;
  logic [3:0]  media_code;
  logic [15:0] media_ctrl;
  logic        coax_start, coax_stop, search_fail;

  int checks = 0;
  int errors = 0;
  int starts = 0;
  int stops = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  media_autoselect #(.TICKS_PER_TENTH(2)) uut (
    .clk(clk), .rst_n(rst_n), .present_mask(present_mask),
    .override_code(override_code), .default_code(default_code),
    .autosel_en(autosel_en), .link_up(link_up), .media_code(media_code),
    .media_ctrl(media_ctrl), .coax_start(coax_start), .coax_stop(coax_stop),
    .search_fail(search_fail)
  );

  always @(negedge clk) begin
    if (coax_start) starts++;
    if (coax_stop)  stops++;
  end

  function automatic logic [7:0] bit_for(input int c);
    case (c)
      0: return 8'h08;  1: return 8'h20;  3: return 8'h10;
      4: return 8'h02;  5: return 8'h04;  6: return 8'h40;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic int follow(input int c);
    case (c)
      0: return 3;  3: return 1;  1: return 8;
      4: return 5;  5: return 6;  default: return 0;
    endcase
  endfunction

  function automatic int hunt(input logic [7:0] p);
    int c = 4;
    for (int i = 0; i < 7; i++) begin
      if ((bit_for(c) & p) != 0) return c;
      c = follow(c);
    end
    return -1;
  endfunction

  function automatic logic [15:0] ctrl_for(input int c);
    if (c == 0) return 16'h00C0;
    if (c == 1) return 16'h0008;
    if (c == 4 || c == 5) return 16'h0080;
    return 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    // R9 reset state
    chk("R9 code", media_code, 8);
    chk("R9 ctrl", media_ctrl, 0);
    chk("R9 fail", search_fail, 0);
    chk("R9 pulses", {coax_start, coax_stop}, 0);
    rst_n = 1'b1;
    step(2);

    // R2 default mode over every default code, one cycle latency
    for (int d = 0; d <= 8; d++) begin
      default_code = 4'(d);
      step(1);
      chk("R2 default", media_code, d);
      chk("R4 ctrl", media_ctrl, ctrl_for(d));
    end
    // R8 present change ignored outside automatic mode
    present_mask = 8'h02;
    step(4);
    chk("R8 ignore", media_code, 8);

    // R1 every override value
    for (int o = 0; o < 7; o++) begin
      override_code = 3'(o);
      step(1);
      chk("R1 override", media_code, (o == 2) ? 0 : o);
    end
    present_mask = 8'h40;
    autosel_en = 1'b1;
    step(4);
    chk("R8 override holds", media_code, 6);
    override_code = 3'd7;

    // R3 sweep of every present vector, link healthy
    default_code = 4'd0;
    for (int p = 0; p < 256; p++) begin
      present_mask = 8'(p);
      step(14);
      if (hunt(8'(p)) < 0) begin
        chk("R7 fallback", media_code, 0);
        chk("R7 flag", search_fail, 1);
      end else begin
        chk("R3 hunt", media_code, hunt(8'(p)));
        chk("R4 ctrl", media_ctrl, ctrl_for(hunt(8'(p))));
        chk("R7 clear", search_fail, 0);
      end
    end

    // R7 fallback to a non-zero default
    default_code = 4'd5;
    present_mask = 8'h00;
    step(14);
    chk("R7 code", media_code, 5);
    chk("R7 ctrl", media_ctrl, 16'h0080);
    chk("R7 flag", search_fail, 1);
    present_mask = 8'h40;
    step(14);
    chk("R7 restart", media_code, 6);
    chk("R7 flag clear", search_fail, 0);

    // R6 coax pulses
    starts = 0;
    stops = 0;
    present_mask = 8'h10;
    step(14);
    chk("R6 code", media_code, 3);
    chk("R6 start", starts, 1);
    chk("R6 no stop", stops, 0);
    present_mask = 8'h02;
    step(14);
    chk("R6 stop", stops, 1);
    chk("R6 start once", starts, 1);

    // R5 settle then link-down fallback along the chain
    link_up = 1'b0;
    present_mask = 8'h06;
    step(20);
    chk("R5 still settling", media_code, 4);
    step(20);
    chk("R5 moved on", media_code, 5);
    step(40);
    chk("R5 chain end", media_code, 8);
    chk("R4 ctrl", media_ctrl, 0);
    link_up = 1'b1;
    step(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule